// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire (I2C) serial EEPROM, built around a byte-addressable array kept in on-chip storage. It runs on a fast system clock and oversamples the bus. SCL and SDA pass through a synchronizer, which finds clock edges and START/STOP conditions. SDA is driven only through an open-drain enable: a high `sda_oe` pulls the line low.

A controller addresses the target with a seven-bit select made of the fixed code `1010` and the three strap pins, followed by a direction bit. For a write, the controller sends a two-byte word address and then data bytes. The data bytes go into a one-page staging buffer. A STOP commits the buffer to the array during a self-timed write window of `WR_CYCLES` clocks. While that window runs, the target refuses its own address, so the controller can poll for completion. Reads come in three forms. A current-address read uses the address counter as it stands. A random read sets the counter with a dummy write and then issues a repeated START. A sequential read keeps returning bytes while the controller acknowledges each one.

The array holds 2^`AW` bytes. Its pages are 2^`PAGE_AW` bytes. When `AW` is 16 the array is the full 64K x 8; the default keeps it small. Word-address bits above `AW` are dropped. There is no streaming interface: data moves only over the serial bus, so no back-pressure rules apply. The array resets to the erased value 0xFF.

Top module: `eeprom_twowire_target`

## Requirements
- R1: A byte received right after START whose bits 7..1 equal {1010, dev_sel[2:0]} (bit 7 first) is acknowledged by a low SDA during the ninth clock. Bit 0 picks the direction, with 1 meaning read.
- R2: After reset, and after an address byte that does not match, `sda_oe` stays low until the next START.
- R3: In a write, the first two bytes after the address are the word address, high byte first. Every byte is acknowledged. Each data byte lands in the array only after the STOP that ends the transaction.
- R4: During a write, the address counter advances only in its low `PAGE_AW` bits and wraps within the page while the upper bits hold. A later byte that reaches an offset already written in the same transaction replaces the earlier byte.
- R5: A random read returns the byte at the word address loaded by a dummy write that is followed by a repeated START with the direction bit 1.
- R6: A current-address read returns the byte one above the last address written or read.
- R7: A sequential read returns consecutive bytes while the controller acknowledges. Past address 2^AW-1 it continues at 0. A controller NACK ends the read, and the target releases SDA.
- R8: For `WR_CYCLES` clocks after a STOP that commits data, an address byte gets a NACK. After that window it gets an ACK again.
- R9: While `wr_lock` is high at the STOP, the array is unchanged and no busy window starts. The address and data bytes are still acknowledged.
- R10: A START in the middle of a byte aborts the transaction and drops any staged data. A STOP with no staged data starts no busy window. After any STOP the target is idle with SDA released.
- R11: The target samples SDA on SCL rising edges and changes its SDA drive only after an SCL falling edge, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| dev_sel | input | 3 | Strap value compared against address bits 3..1 |
| wr_lock | input | 1 | Write protect; high blocks all array updates |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
Four properties are checked on every cycle. First, the SDA drive only changes right after a synchronized SCL fall, a START or a STOP. Second, the target stays silent while idle and during the busy window's address slot. Third, every STOP leaves the target idle and released. Fourth, a busy window only ever opens from an unlocked STOP. Only the bench scenarios can show the data itself: page wrap and overwrite, wrap across the whole array on reads, the current-address counter, the blocking effect of `wr_lock`, and the dropping of staged bytes on an aborting START. The bench checks these against a behavioural model of the array and its address counter.

// File: rtl/twt_pkg.sv
package twt_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RDAT
  } twt_state_e;
endpackage

// File: rtl/twt_bus_sense.sv
module twt_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC-1:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC-2:0], scl_i};
      sda_p <= {sda_p[SYNC-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_p[SYNC-1];
  assign sda_s     = sda_p[SYNC-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // line changes while the clock stays high
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twt_store.sv
module twt_store #(
  parameter int AW        = 10,
  parameter int PAGE_AW   = 7,
  parameter int WR_CYCLES = 300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stg_clr,
  input  logic               stg_we,
  input  logic [PAGE_AW-1:0] stg_off,
  input  logic [7:0]         stg_data,
  input  logic               commit,
  input  logic [AW-PAGE_AW-1:0] commit_row,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  output logic               busy
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [7:0] mem [DEPTH];
  logic [7:0] stage [PAGE];
  logic [PAGE-1:0] vld;
  logic [AW-PAGE_AW-1:0] row_q;
  logic [TW-1:0] timer;
  logic [PAGE_AW-1:0] idx;

  assign idx     = timer[PAGE_AW-1:0];
  assign rd_data = mem[rd_addr];

  // one staged byte per clock moves into the array during the busy window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      busy  <= 1'b0;
      timer <= '0;
      row_q <= '0;
    end else if (commit) begin
      busy  <= 1'b1;
      timer <= '0;
      row_q <= commit_row;
    end else if (busy) begin
      if (timer < TW'(PAGE) && vld[idx]) mem[{row_q, idx}] <= stage[idx];
      if (timer == TW'(WR_CYCLES - 1)) busy <= 1'b0;
      timer <= timer + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[g]   <= 1'b0;
          stage[g] <= 8'h00;
        end else if (stg_clr) begin
          vld[g] <= 1'b0;
        end else if (stg_we && stg_off == PAGE_AW'(g)) begin
          vld[g]   <= 1'b1;
          stage[g] <= stg_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/eeprom_twowire_target.sv
module eeprom_twowire_target
  import twt_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PAGE_AW   = 7,
  parameter int WR_CYCLES = 300,
  parameter int SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  input  logic       wr_lock,
  output logic       sda_oe
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, byte_done, dev_hit, commit;
  logic stg_clr, stg_we;
  logic [7:0] rd_data;

  twt_state_e st;
  logic [3:0] cnt;
  logic slot, rw, mack, pending;
  logic [7:0] shr, txb, hi_q;
  logic [AW-1:0] addr;

  twt_bus_sense #(.SYNC(SYNC)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign byte_done = scl_fall && !slot && cnt == 4'd8 && st != S_IDLE;
  assign dev_hit   = shr[7:1] == {DEV_CODE, dev_sel} && !busy;
  assign stg_clr   = byte_done && st == S_ALO;
  assign stg_we    = byte_done && st == S_WDAT;
  assign commit    = stop_evt && pending && !wr_lock;

  twt_store #(.AW(AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .stg_clr(stg_clr), .stg_we(stg_we),
    .stg_off(addr[PAGE_AW-1:0]), .stg_data(shr),
    .commit(commit), .commit_row(addr[AW-1:PAGE_AW]),
    .rd_addr(addr), .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; slot <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      pending <= 1'b0; shr <= '0; txb <= '0; hi_q <= '0; addr <= '0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= S_DEV; cnt <= '0; slot <= 1'b0; sda_oe <= 1'b0; pending <= 1'b0;
    end else if (stop_evt) begin
      st <= S_IDLE; cnt <= '0; slot <= 1'b0; sda_oe <= 1'b0; pending <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (!slot && cnt < 4'd8) begin
          shr <= {shr[6:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (slot) begin
          mack <= !sda_s;
        end
      end else if (scl_fall && !slot) begin
        if (cnt == 4'd8) begin
          slot <= 1'b1;
          unique case (st)
            S_DEV: begin
              if (dev_hit) begin
                sda_oe <= 1'b1;
                rw     <= shr[0];
              end else begin
                st <= S_IDLE; slot <= 1'b0; cnt <= '0;
              end
            end
            S_AHI: begin hi_q <= shr; sda_oe <= 1'b1; end
            S_ALO: begin addr <= AW'({hi_q, shr}); sda_oe <= 1'b1; end
            S_WDAT: begin
              addr    <= {addr[AW-1:PAGE_AW], addr[PAGE_AW-1:0] + 1'b1};
              pending <= 1'b1;
              sda_oe  <= 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (st == S_RDAT && cnt != 4'd0) begin
          sda_oe <= ~txb[3'd7 - cnt[2:0]];
        end
      end else if (scl_fall) begin
        slot   <= 1'b0;
        cnt    <= '0;
        sda_oe <= 1'b0;
        unique case (st)
          S_DEV:  st <= rw ? S_RDAT : S_AHI;
          S_AHI:  st <= S_ALO;
          S_ALO:  st <= S_WDAT;
          S_RDAT: if (!mack) st <= S_IDLE;
          default: st <= st;
        endcase
        if ((st == S_DEV && rw) || (st == S_RDAT && mack)) begin
          txb    <= rd_data;
          sda_oe <= ~rd_data[7];
          addr   <= addr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twt_checker.sv
module twt_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_lock,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic busy,
  input logic in_idle,
  input logic dev_slot
);
  a_r11_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r8_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_slot && busy) |-> !sda_oe);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (in_idle && !sda_oe));

  a_r9_locked_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_evt) && !$past(wr_lock)));
endmodule

bind eeprom_twowire_target twt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .sda_oe(sda_oe),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
  .busy(busy), .in_idle(st == twt_pkg::S_IDLE),
  .dev_slot(st == twt_pkg::S_DEV && slot)
);

// File: tb/sim_eeprom_twowire_target.sv
module sim_eeprom_twowire_target;
  localparam int AW = 10;
  localparam int MASK = (1 << AW) - 1;
  localparam int PAGE = 128;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DW = 8'hAA;
  localparam logic [7:0] DR = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wr_lock = 1'b0;
  logic sda_i, sda_oe;
  int total = 0, fails = 0;
  bit done = 0;

  int mm [int];
  int stg [int];
  int maddr = 0;

  always #10 clk = ~clk;
  assign sda_i = sda_m & ~sda_oe;

  eeprom_twowire_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_i),
    .dev_sel(SEL), .wr_lock(wr_lock), .sda_oe(sda_oe)
  );

  function automatic int mrd(int a);
    return mm.exists(a) ? mm[a] : 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic s);
    sda_m = b; repeat (4) @(negedge clk);
    scl = 1'b1; repeat (4) @(negedge clk);
    s = sda_i; repeat (4) @(negedge clk);
    scl = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; repeat (4) @(negedge clk);
    scl = 1'b1; repeat (4) @(negedge clk);
    sda_m = 1'b0; repeat (4) @(negedge clk);
    scl = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; repeat (4) @(negedge clk);
    scl = 1'b1; repeat (4) @(negedge clk);
    sda_m = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitx(v[i], s);
    bitx(1'b1, s);
    ack = !s;
  endtask

  task automatic recv(input logic ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, s); v[i] = s; end
    bitx(!ack, s);
  endtask

  task automatic wr(input int a, input int d[$], input string tag, input bit settle);
    logic ack;
    int row;
    start_c();
    send(DW, ack); chk({tag, " R1 address ack"}, ack, 1);
    send(8'((a >> 8) & 255), ack); chk({tag, " R3 high address ack"}, ack, 1);
    send(8'(a & 255), ack); chk({tag, " R3 low address ack"}, ack, 1);
    maddr = a & MASK;
    row = maddr & ~(PAGE - 1);
    stg.delete();
    foreach (d[i]) begin
      send(8'(d[i]), ack); chk({tag, " R3 data ack"}, ack, 1);
      stg[maddr & (PAGE - 1)] = d[i];
      maddr = row | ((maddr + 1) & (PAGE - 1));
    end
    stop_c();
    if (!wr_lock) foreach (stg[k]) mm[row | k] = stg[k];
    if (settle) repeat (400) @(negedge clk);
  endtask

  task automatic rd_bytes(input int n, input string tag);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, v);
      chk({tag, " R11 read data"}, v, mrd(maddr));
      maddr = (maddr + 1) & MASK;
    end
    stop_c();
  endtask

  task automatic rd_rand(input int a, input int n, input string tag);
    logic ack;
    start_c();
    send(DW, ack); chk({tag, " R1 ack"}, ack, 1);
    send(8'((a >> 8) & 255), ack); chk({tag, " R3 ack"}, ack, 1);
    send(8'(a & 255), ack); chk({tag, " R3 ack"}, ack, 1);
    maddr = a & MASK;
    start_c();
    send(DR, ack); chk({tag, " R1 read ack"}, ack, 1);
    rd_bytes(n, tag);
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ack;
    start_c();
    send(DR, ack); chk({tag, " R1 read ack"}, ack, 1);
    rd_bytes(n, tag);
  endtask

  task automatic poll(input int exp, input string tag);
    logic ack;
    start_c();
    send(DW, ack); chk(tag, ack, exp);
    stop_c();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(negedge clk); cyc++; end
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic ack;
    int q [$];
    repeat (5) @(negedge clk);
    chk("R2 reset drive", sda_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 reset released", sda_oe, 0);

    // R2: foreign select, then further bytes stay unanswered
    start_c();
    send(8'hA2, ack); chk("R2 wrong strap nack", ack, 0);
    send(8'h00, ack); chk("R2 silent after mismatch", ack, 0);
    stop_c();
    start_c();
    send(8'hBA, ack); chk("R1 wrong code nack", ack, 0);
    stop_c();

    // R3 byte write, R8 acknowledge polling
    q = '{8'h5A};
    wr(16'h0123, q, "byte", 0);
    poll(0, "R8 nack while busy");
    repeat (400) @(negedge clk);
    poll(1, "R8 ack after window");

    rd_rand(16'h0123, 1, "R5 random");
    rd_cur(1, "R6 current");

    // R4 page wrap inside row 1
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr(16'h00FE, q, "R4 wrap", 1);
    rd_cur(2, "R6 after wrap");
    rd_rand(16'h00FE, 3, "R4 readback");

    // R7 sequential wrap across the top of the array
    q = '{8'h77};
    wr(MASK, q, "top", 1);
    q = '{8'h66};
    wr(0, q, "bottom", 1);
    rd_rand(MASK - 1, 4, "R7 seq wrap");

    // R9 write protect
    wr_lock = 1'b1;
    q = '{8'h99, 8'h98};
    wr(16'h0200, q, "R9 locked", 0);
    poll(1, "R9 no busy window");
    wr_lock = 1'b0;
    rd_rand(16'h0200, 2, "R9 unchanged");

    // R10 abort mid-byte by START
    start_c();
    send(DW, ack); chk("R10 ack", ack, 1);
    send(8'h03, ack); chk("R10 ack", ack, 1);
    send(8'h00, ack); chk("R10 ack", ack, 1);
    send(8'hC3, ack); chk("R10 ack", ack, 1);
    for (int i = 0; i < 4; i++) bitx(1'b0, ack);
    maddr = 16'h0301;
    start_c();
    send(DR, ack); chk("R10 read after abort", ack, 1);
    rd_bytes(1, "R10 dropped data");
    poll(1, "R10 no window after stopless data");
    rd_rand(16'h0301, 1, "R10 array kept");

    // R4 overflow: 130 bytes overwrite offsets 0 and 1
    q = {};
    for (int i = 0; i < 130; i++) q.push_back(i);
    wr(16'h0180, q, "R4 overflow", 1);
    rd_rand(16'h0180, 4, "R4 overwrite");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule